// File: doc/BRIEF.md
# CAN bit timing and sampler

This block turns the module clock into CAN bit times and recovers one received bit per bit time. A programmable prescaler cuts the clock into time quanta. Each bit time is one synchronization quantum followed by two programmable time segments. The receive line is read at the sample point, which lies at the end of the first segment.

The line can be read once per bit. It can also be read three times per bit, and the result is then the majority of the three readings. The timing configuration lives in a register that can be read at any time. Writes to it land only while initialization is both requested and acknowledged. While initialization mode is active, the timing counters stand still. They restart from the synchronization quantum once that mode is left.

Edge-driven resynchronization, frame decoding and transmission belong to neighbouring blocks.

Top module: `can_bit_sampler`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cfg_rdata` reads 0, `cfg_invalid` is 0, and `bit_start` and `rx_valid` are 0.
- R2: The configuration word `cfg_wdata[13:0]` is laid out as follows. Bits 13:8 hold the prescaler field PF. Bit 7 is the sample-mode bit S. Bits 6:4 hold the second-segment field F2. Bits 3:0 hold the first-segment field F1. A write pulse on `cfg_wr` is stored only when `init_req` and `init_ack` are both 1 in that cycle. At any other time the stored word, shown on `cfg_rdata`, stays unchanged.
- R3: One time quantum lasts P = PF+1 clock cycles, so PF=0 gives 1 clock and PF=63 gives 64 clocks.
- R4: A bit time lasts N = 1 + (F1+1) + (F2+1) quanta, that is N·P clocks. `bit_start` is high for exactly one clock at the start of each synchronization quantum.
- R5: With S=0, `rx_valid` is high for one clock, starting (F1+2)·P−1 clocks after the `bit_start` pulse of the same bit. `rx_bit` then equals the value `rx_in` had at the clock edge that raised `rx_valid`, which is the last clock of quantum F1+1.
- R6: With S=1, `rx_bit` is the majority of three `rx_in` readings. These are taken at the last clock of quanta F1−1, F1 and F1+1. The readings have the same timing as in R5, and `rx_valid` has the same timing as in R5.
- R7: `cfg_invalid` is 1 exactly when the stored word has S=1 and F1=0, which is a first phase segment shorter than 2 quanta. While it is 1, `bit_start` and `rx_valid` stay 0.
- R8: While `init_req` or `init_ack` is 1, no strobes are produced and the counters are held. On the first clock edge after both are 0, `bit_start` rises and a new bit time begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| cfg_wr | input | 1 | Configuration write pulse |
| cfg_wdata | input | 14 | Configuration word to write |
| cfg_rdata | output | 14 | Stored configuration word |
| cfg_invalid | output | 1 | Stored word asks for triple sampling with too short a first segment |
| rx_in | input | 1 | Receive line |
| rx_bit | output | 1 | Last resolved bit value |
| rx_valid | output | 1 | One-clock strobe when `rx_bit` is updated |
| bit_start | output | 1 | One-clock strobe at the start of each bit time |

## Verification
Two pairs of events can land together, and the bench provokes both.

The first pair is a configuration write and the end of initialization mode. The bench drives a write with only one of the two initialization flags set. It also writes while the counters are running. In both cases it judges by reading back the word and by checking that the running bit timing is undisturbed.

The second pair is the earliest vote reading and the synchronization quantum. With triple sampling and F1=1, the first reading falls on the last clock of the synchronization quantum. The bench runs that case directly and also in random configurations, driving a fresh random line value every clock. An independent position-in-bit model predicts every `bit_start`, `rx_valid` and voted `rx_bit`.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int PRESC_W_D = 6;
  localparam int SEG1_W_D  = 4;
  localparam int SEG2_W_D  = 3;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int PRESC_W = can_bt_pkg::PRESC_W_D,
  parameter int SEG1_W  = can_bt_pkg::SEG1_W_D,
  parameter int SEG2_W  = can_bt_pkg::SEG2_W_D,
  localparam int CW     = PRESC_W + 1 + SEG2_W + SEG1_W,
  localparam int MODE_B = SEG1_W + SEG2_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          init_req,
  input  logic          init_ack,
  output logic [CW-1:0] cfg_q,
  output logic          invalid_q
);
  logic wr_ok;
  assign wr_ok = wr && init_req && init_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      invalid_q <= 1'b0;
    end else if (wr_ok) begin
      cfg_q     <= wdata;
      invalid_q <= wdata[MODE_B] && (wdata[SEG1_W-1:0] == '0);
    end
  end

  // R1: reset clears the stored word and the flag
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && !invalid_q));
  // R2: outside initialization the word is frozen
  a_r2_locked: assert property (@(posedge clk) disable iff (rst)
    !(init_req && init_ack) |=> $stable(cfg_q));
endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int PRESC_W = can_bt_pkg::PRESC_W_D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic [PRESC_W-1:0] div,
  output logic               tick,
  output logic               q_first
);
  logic [PRESC_W-1:0] cnt;

  assign tick    = (cnt == div);
  assign q_first = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || hold)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R3: a quantum ends by returning to its first clock
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !hold) |=> q_first);
  // R3: the count never passes the programmed limit
  a_r3_bound: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (cnt <= div || $past(hold)));
endmodule

// File: rtl/can_bt_seg.sv
module can_bt_seg #(
  parameter int SEG1_W = can_bt_pkg::SEG1_W_D,
  parameter int SEG2_W = can_bt_pkg::SEG2_W_D,
  localparam int QW    = $clog2((1 << SEG1_W) + (1 << SEG2_W) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              tick,
  input  logic              q_first,
  input  logic [SEG1_W-1:0] seg1,
  input  logic [SEG2_W-1:0] seg2,
  output logic              bit_start_o,
  output logic              en_a,
  output logic              en_b,
  output logic              en_c
);
  logic [QW-1:0] q;
  logic [QW-1:0] last_q;
  logic [QW-1:0] smp_q;

  assign last_q = QW'(seg1) + QW'(seg2) + QW'(2);
  assign smp_q  = QW'(seg1) + QW'(1);

  assign en_c = tick && (q == smp_q);
  assign en_b = tick && (q == QW'(seg1));
  assign en_a = tick && (seg1 != '0) && (q == QW'(seg1) - QW'(1));

  always_ff @(posedge clk) begin
    if (rst || hold)         q <= '0;
    else if (tick)           q <= (q == last_q) ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) bit_start_o <= 1'b0;
    else     bit_start_o <= !hold && q_first && (q == '0);
  end

  // R4: quantum index stays inside the bit time
  a_r4_bound: assert property (@(posedge clk) disable iff (rst)
    q <= last_q);
  // R4: the last quantum is followed by the sync quantum
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (!hold && tick && q == last_q) |=> (q == '0));
endmodule

// File: rtl/can_bt_vote.sv
module can_bt_vote #(
  parameter bit TRIPLE_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic mode3,
  input  logic en_a,
  input  logic en_b,
  input  logic en_c,
  input  logic rx_in,
  output logic rx_bit_o,
  output logic rx_valid_o
);
  logic result;

  generate
    if (TRIPLE_EN) begin : g_triple
      logic s_a, s_b;
      always_ff @(posedge clk) begin
        if (rst) begin
          s_a <= 1'b0;
          s_b <= 1'b0;
        end else begin
          if (en_a) s_a <= rx_in;
          if (en_b) s_b <= rx_in;
        end
      end
      assign result = mode3 ? can_bt_pkg::vote3(s_a, s_b, rx_in) : rx_in;

      // R6: voted bit is the majority of the three readings
      a_r6_vote: assert property (@(posedge clk) disable iff (rst)
        (!hold && mode3 && en_c) |=>
          (rx_bit_o == can_bt_pkg::vote3($past(s_a), $past(s_b), $past(rx_in))));
    end else begin : g_single
      assign result = rx_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_bit_o   <= 1'b0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= !hold && en_c;
      if (!hold && en_c) rx_bit_o <= result;
    end
  end

  // R5: single-reading bit equals the line at the sample point
  a_r5_single: assert property (@(posedge clk) disable iff (rst)
    (!hold && !mode3 && en_c) |=> (rx_valid_o && rx_bit_o == $past(rx_in)));
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler #(
  parameter int PRESC_W   = can_bt_pkg::PRESC_W_D,
  parameter int SEG1_W    = can_bt_pkg::SEG1_W_D,
  parameter int SEG2_W    = can_bt_pkg::SEG2_W_D,
  parameter bit TRIPLE_EN = 1'b1,
  localparam int CW       = PRESC_W + 1 + SEG2_W + SEG1_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_req,
  input  logic          init_ack,
  input  logic          cfg_wr,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata,
  output logic          cfg_invalid,
  input  logic          rx_in,
  output logic          rx_bit,
  output logic          rx_valid,
  output logic          bit_start
);
  localparam int MODE_B = SEG1_W + SEG2_W;
  localparam int PRE_LO = MODE_B + 1;

  logic [CW-1:0] cfg_q;
  logic          invalid_q;
  logic          hold, tick, q_first, en_a, en_b, en_c;

  can_bt_cfg #(.PRESC_W(PRESC_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .init_req(init_req), .init_ack(init_ack),
    .cfg_q(cfg_q), .invalid_q(invalid_q)
  );

  assign hold        = init_req || init_ack || invalid_q;
  assign cfg_rdata   = cfg_q;
  assign cfg_invalid = invalid_q;

  can_bt_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .hold(hold), .div(cfg_q[CW-1:PRE_LO]),
    .tick(tick), .q_first(q_first)
  );

  can_bt_seg #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W)) u_seg (
    .clk(clk), .rst(rst), .hold(hold), .tick(tick), .q_first(q_first),
    .seg1(cfg_q[SEG1_W-1:0]), .seg2(cfg_q[MODE_B-1:SEG1_W]),
    .bit_start_o(bit_start), .en_a(en_a), .en_b(en_b), .en_c(en_c)
  );

  can_bt_vote #(.TRIPLE_EN(TRIPLE_EN)) u_vote (
    .clk(clk), .rst(rst), .hold(hold), .mode3(cfg_q[MODE_B]),
    .en_a(en_a), .en_b(en_b), .en_c(en_c), .rx_in(rx_in),
    .rx_bit_o(rx_bit), .rx_valid_o(rx_valid)
  );

  // R7: an invalid word silences both strobes
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_invalid |-> (!bit_start && !rx_valid));
  // R8: initialization mode silences both strobes on the next clock
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (init_req || init_ack) |=> (!bit_start && !rx_valid));
  // R4: the two strobes never coincide
  a_r4_apart: assert property (@(posedge clk) disable iff (rst)
    !(bit_start && rx_valid));
endmodule

// File: tb/can_bit_sampler_tb.sv
module can_bit_sampler_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_req = 1'b0, init_ack = 1'b0, cfg_wr = 1'b0, rx_in = 1'b0;
  logic [13:0] cfg_wdata = '0;
  logic [13:0] cfg_rdata;
  logic cfg_invalid, rx_bit, rx_valid, bit_start;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  can_bit_sampler u_dut (
    .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_invalid(cfg_invalid), .rx_in(rx_in), .rx_bit(rx_bit),
    .rx_valid(rx_valid), .bit_start(bit_start)
  );

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input logic [13:0] d, input logic rq, input logic ak);
    @(negedge clk);
    init_req = rq; init_ack = ak; cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // runs nbits bit times after release, checking every clock
  task automatic run_bits(input logic [13:0] c, input int nbits, input bit poke);
    int p, t1, n, len;
    logic a, b, rxv, expbit;
    p = int'(c[13:8]) + 1;
    t1 = int'(c[3:0]) + 1;
    n = 1 + t1 + int'(c[6:4]) + 1;
    len = nbits * p * n;
    a = 1'b0; b = 1'b0; expbit = 1'b0;
    write_cfg(c, 1'b1, 1'b1);
    chk("R2 readback", int'(cfg_rdata), int'(c));
    @(negedge clk);
    init_req = 1'b0; init_ack = 1'b0;
    rx_in = 1'($urandom);
    for (int m = 1; m <= len; m++) begin
      int pos;
      rxv = rx_in;
      @(posedge clk);
      @(negedge clk);
      pos = (m - 1) % (p * n);
      if (c[7] && pos == (t1 - 1) * p - 1) a = rxv;
      if (c[7] && pos == t1 * p - 1) b = rxv;
      chk((m == 1) ? "R8 restart" : "R4 bit_start", int'(bit_start), int'(pos == 0));
      chk(c[7] ? "R6 rx_valid" : "R5 rx_valid", int'(rx_valid), int'(pos == (t1 + 1) * p - 1));
      if (pos == (t1 + 1) * p - 1) begin
        expbit = c[7] ? maj(a, b, rxv) : rxv;
        chk(c[7] ? "R6 vote" : "R5 bit", int'(rx_bit), int'(expbit));
      end
      cfg_wr = poke && (m == 3);
      cfg_wdata = ~c;
      rx_in = 1'($urandom);
    end
    chk("R2 ignored", int'(cfg_rdata), int'(c));
    @(negedge clk);
    init_req = 1'b1; init_ack = 1'b1;
    @(negedge clk);
    chk("R8 held bs", int'(bit_start), 0);
    chk("R8 held rv", int'(rx_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdata", int'(cfg_rdata), 0);
    chk("R1 invalid", int'(cfg_invalid), 0);
    chk("R1 bs", int'(bit_start), 0);
    chk("R1 rv", int'(rx_valid), 0);
    init_req = 1'b1; init_ack = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after rst", int'(cfg_rdata), 0);
    // R2: write with request only is dropped
    write_cfg(14'h0A25, 1'b1, 1'b1);
    write_cfg(14'h1133, 1'b0, 1'b1);
    chk("R2 ack only", int'(cfg_rdata), 14'h0A25);
    write_cfg(14'h1133, 1'b1, 1'b0);
    chk("R2 req only", int'(cfg_rdata), 14'h0A25);
    // directed corners
    run_bits({6'd0, 1'b0, 3'd0, 4'd0}, 4, 1'b1);   // R3 P=1 shortest bit
    run_bits({6'd2, 1'b1, 3'd0, 4'd1}, 4, 1'b0);   // R6 first reading in sync quantum
    run_bits({6'd63, 1'b0, 3'd7, 4'd15}, 2, 1'b1); // R3 P=64 longest bit
    run_bits({6'd1, 1'b1, 3'd7, 4'd15}, 3, 1'b0);  // R6 long segments
    // R7: triple sampling with one-quantum first segment
    write_cfg({6'd3, 1'b1, 3'd2, 4'd0}, 1'b1, 1'b1);
    chk("R7 flag set", int'(cfg_invalid), 1);
    @(negedge clk);
    init_req = 1'b0; init_ack = 1'b0;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      rx_in = 1'($urandom);
      if (bit_start || rx_valid) chk("R7 strobe", 1, 0);
    end
    chk("R7 quiet", int'(bit_start) + int'(rx_valid), 0);
    write_cfg({6'd3, 1'b0, 3'd2, 4'd0}, 1'b1, 1'b1);
    chk("R7 flag clear", int'(cfg_invalid), 0);
    // random configurations
    for (int k = 0; k < 18; k++) begin
      logic [13:0] c;
      c = 14'($urandom);
      c[13:12] = 2'b00;
      if (c[7] && c[3:0] == 4'd0) c[3:0] = 4'd1;
      run_bits(c, 2 + (k % 2), k[0]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #700000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule